// File: doc/BRIEF.md
# Receive/Transmit Hardware Handshake Controller

This block automates the RTS/CTS handshake for a single UART channel. On the receive side it compares the receive FIFO fill count with a ladder of four trigger levels. A 2-bit select picks one of these levels as the interrupt level. The interrupt is raised when the fill reaches that level. The RTS pin is driven to its not-ready state (logic 1) only when the fill reaches the next rung up. It returns to ready (logic 0) only after the fill drains below the rung one step down. This hysteresis keeps RTS from chattering around a single threshold. When automatic RTS is off, the pin carries a software-supplied level.

On the transmit side the CTS pin is brought through a two-flop synchronizer. The synchronized value decides a transmit-permit signal for the serializer. The permit is re-evaluated only while the serializer reports that it is idle between characters, so a character already on the line always finishes. Each direction has its own enable. The register that holds the enables, the FIFO storage and the serializer all lie outside this block.

Top module: `auto_flow_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, rts_out is 0, tx_permit is 1 and rx_thr_irq is 0.
- R2: The trigger ladder is 8, 16, 56, 60 for trig_sel values 0, 1, 2, 3. rx_thr_irq becomes 1 one clock after fill_count is at or above the selected level.
- R3: rx_thr_irq becomes 0 one clock after fill_count is below the selected level.
- R4: With auto_rts_en = 1, rts_out becomes 1 one clock after fill_count reaches the next higher ladder level. For trig_sel = 3 the next higher level saturates to 60.
- R5: With auto_rts_en = 1, rts_out becomes 0 one clock after fill_count is below the next lower ladder level. For trig_sel = 0 the next lower level saturates to 8.
- R6: With auto_rts_en = 1 and fill_count inside the window [lower level, higher level), rts_out keeps its previous value.
- R7: With auto_rts_en = 0, rts_out equals sw_rts one clock later. The automatic not-ready state is cleared, so re-enabling the mode inside the window gives rts_out = 0.
- R8: A change on cts_in reaches tx_permit on the third rising clock edge after it, and not on the second.
- R9: With auto_cts_en = 1 and tx_busy = 0, a synchronized cts_in of 1 drives tx_permit to 0, and a synchronized cts_in of 0 drives it back to 1.
- R10: While tx_busy = 1, tx_permit holds its value whatever cts_in and auto_cts_en do.
- R11: With auto_cts_en = 0 and tx_busy = 0, tx_permit is 1 whatever cts_in is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_count | input | 7 | Current receive FIFO occupancy (0..64) |
| trig_sel | input | 2 | Interrupt trigger level select |
| auto_rts_en | input | 1 | Enable for automatic RTS |
| auto_cts_en | input | 1 | Enable for automatic CTS |
| sw_rts | input | 1 | RTS level used when automatic RTS is off |
| cts_in | input | 1 | CTS pin, asynchronous, 1 = stop |
| tx_busy | input | 1 | Serializer is shifting a character |
| rts_out | output | 1 | RTS pin, 1 = not ready |
| tx_permit | output | 1 | Serializer may start a new character |
| rx_thr_irq | output | 1 | Receive trigger level interrupt |

## Verification
The assertions assume that fill_count stays within 0..64 and that trig_sel, the enables, sw_rts and tx_busy are synchronous to clk. cts_in is the only input that may change at any time. The stimulus changes every input just after a falling edge. It steps fill_count only through legal values around each ladder rung, and it drives tx_busy as a level that only a serializer would produce. The assertions on the permit path look at the synchronized CTS value and never at the raw pin, so they remain valid for an asynchronous pin.

// File: rtl/flow_pkg.sv
// Package: shared constants and helpers for the handshake controller.
// Assumes a four-rung trigger ladder indexed by a 2-bit select.
package flow_pkg;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned NUM_LVL = 1 << SEL_W;

    typedef logic [SEL_W-1:0] lvl_idx_t;

    // Index of the rung above, saturating at the top rung.
    function automatic lvl_idx_t step_up(input lvl_idx_t idx);
        return (idx == lvl_idx_t'(NUM_LVL - 1)) ? idx : idx + lvl_idx_t'(1);
    endfunction

    // Index of the rung below, saturating at the bottom rung.
    function automatic lvl_idx_t step_down(input lvl_idx_t idx);
        return (idx == lvl_idx_t'(0)) ? idx : idx - lvl_idx_t'(1);
    endfunction
endpackage

// File: rtl/cts_sync.sv
// Module: multi-flop synchronizer for the asynchronous CTS pin.
// Assumes STAGES >= 2. The output is reset to the "clear to send" level (0).
module cts_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

    AST_SYNC_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(chain_q) |=> (dout == $past(chain_q[STAGES-1]))) else $error("sync"); // R8
endmodule

// File: rtl/rx_thresh.sv
// Module: receive-side ladder compare, interrupt flag and RTS hysteresis.
// Assumes fill is in 0..2**CNT_W-1 and that the ladder levels ascend.
// rts_hold is the automatic not-ready state and is cleared while disabled.
module rx_thresh
    import flow_pkg::*;
#(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned LVL0  = 8,
    parameter int unsigned LVL1  = 16,
    parameter int unsigned LVL2  = 56,
    parameter int unsigned LVL3  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill,
    input  lvl_idx_t         sel,
    input  logic             auto_en,
    output logic             rts_hold,
    output logic             irq
);
    localparam logic [CNT_W-1:0] LVL_TAB [NUM_LVL] = '{
        CNT_W'(LVL0), CNT_W'(LVL1), CNT_W'(LVL2), CNT_W'(LVL3)
    };

    logic [NUM_LVL-1:0] at_or_above;
    lvl_idx_t           up_idx;
    lvl_idx_t           dn_idx;
    logic               reach_hi;
    logic               above_lo;

    // One comparator per ladder rung.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_cmp
        assign at_or_above[g] = (fill >= LVL_TAB[g]);
    end

    // Pick the rungs above and below the selected one.
    always_comb begin
        up_idx   = step_up(sel);
        dn_idx   = step_down(sel);
        reach_hi = at_or_above[up_idx];
        above_lo = at_or_above[dn_idx];
    end

    // Interrupt flag follows the selected rung compare.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= at_or_above[sel];
    end

    // Hysteresis state: set at the upper rung, clear below the lower rung.
    always_ff @(posedge clk) begin
        if (!rst_n)        rts_hold <= 1'b0;
        else if (!auto_en) rts_hold <= 1'b0;
        else if (reach_hi) rts_hold <= 1'b1;
        else if (!above_lo) rts_hold <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= LVL_TAB[sel]) |=> irq) else $error("irq set"); // R2
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < LVL_TAB[sel]) |=> !irq) else $error("irq clear"); // R3
    AST_RTS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fill >= LVL_TAB[step_up(sel)]) |=> rts_hold) else $error("rise"); // R4
    AST_RTS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fill < LVL_TAB[step_down(sel)]) |=> !rts_hold) else $error("fall"); // R5
    AST_RTS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fill >= LVL_TAB[step_down(sel)] && fill < LVL_TAB[step_up(sel)])
        |=> (rts_hold == $past(rts_hold))) else $error("window"); // R6
endmodule

// File: rtl/tx_gate.sv
// Module: transmit permit, re-evaluated only between characters.
// Assumes tx_busy is high for the whole time a character is being shifted.
module tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_s,
    input  logic auto_en,
    input  logic tx_busy,
    output logic permit
);
    // Update the permit only at a character boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        permit <= 1'b1;
        else if (!tx_busy) permit <= !(auto_en && cts_s);
    end

    AST_PERMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(permit)) else $error("held"); // R10
    AST_CTS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && auto_en && cts_s) |=> !permit) else $error("stop"); // R9
    AST_CTS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && auto_en && !cts_s) |=> permit) else $error("go"); // R9
    AST_CTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !auto_en) |=> permit) else $error("off"); // R11
endmodule

// File: rtl/auto_flow_ctrl.sv
// Module: top of the RTS/CTS handshake controller for one UART channel.
// Assumes fill_count is synchronous and in range; cts_in may be asynchronous.
// All outputs are registered; rts_out selects between the automatic state
// and the software level with an enable captured on the same edge.
module auto_flow_ctrl
    import flow_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned LVL0       = 8,
    parameter int unsigned LVL1       = 16,
    parameter int unsigned LVL2       = 56,
    parameter int unsigned LVL3       = 60,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_count,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic             cts_in,
    input  logic             tx_busy,
    output logic             rts_out,
    output logic             tx_permit,
    output logic             rx_thr_irq
);
    logic rts_hold;
    logic auto_q;
    logic sw_q;
    logic cts_s;

    rx_thresh #(
        .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill     (fill_count),
        .sel      (trig_sel),
        .auto_en  (auto_rts_en),
        .rts_hold (rts_hold),
        .irq      (rx_thr_irq)
    );

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cts_in),
        .dout  (cts_s)
    );

    tx_gate u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_s   (cts_s),
        .auto_en (auto_cts_en),
        .tx_busy (tx_busy),
        .permit  (tx_permit)
    );

    // Capture the mode and software level on the same edge as rts_hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            sw_q   <= 1'b0;
        end else begin
            auto_q <= auto_rts_en;
            sw_q   <= sw_rts;
        end
    end

    assign rts_out = auto_q ? rts_hold : sw_q;

    AST_RTS_SOFTWARE: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_out == $past(sw_rts))) else $error("sw"); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rts_out && tx_permit && !rx_thr_irq)) else $error("reset"); // R1
endmodule

// File: tb/auto_flow_ctrl_tb.sv
`timescale 1ns/1ps
module auto_flow_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] fill_count = '0;
    logic [1:0] trig_sel = '0;
    logic       auto_rts_en = 1'b0;
    logic       auto_cts_en = 1'b0;
    logic       sw_rts = 1'b0;
    logic       cts_in = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rts_out, tx_permit, rx_thr_irq;

    always #2.5 clk = ~clk;

    auto_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fill_count(fill_count), .trig_sel(trig_sel),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .sw_rts(sw_rts),
        .cts_in(cts_in), .tx_busy(tx_busy), .rts_out(rts_out),
        .tx_permit(tx_permit), .rx_thr_irq(rx_thr_irq)
    );

    typedef struct {
        string    tag;
        int       due;
        logic [2:0] mask;   // {rts, permit, irq}
        logic [2:0] val;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always @(posedge clk) cyc = cyc + 1;

    // Monitor: compare every expected item whose cycle has come.
    always @(negedge clk) begin
        logic [2:0] act;
        act = {rts_out, tx_permit, rx_thr_irq};
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                checks = checks + 1;
                if ((act & q[i].mask) !== (q[i].val & q[i].mask)) begin
                    errors = errors + 1;
                    $display("FAIL %s: actual {rts,permit,irq}=%b expected %b (mask %b)",
                             q[i].tag, act, q[i].val, q[i].mask);
                end
                q.delete(i);
            end
        end
    end

    // Driver helper: queue an expectation LAT cycles ahead.
    task automatic expect_out(input string tag, input int lat,
                              input logic [2:0] mask, input logic [2:0] val);
        exp_t e;
        e.tag = tag; e.due = cyc + lat; e.mask = mask; e.val = val;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Set fill and check rts/irq one cycle later.
    task automatic rx_step(input string tag, input int f, input logic r, input logic i);
        fill_count = 7'(f);
        expect_out(tag, 1, 3'b101, {r, 1'b0, i});
        wait_cyc(1);
    endtask

    initial begin
        wait_cyc(2);
        expect_out("R1 reset state", 1, 3'b111, 3'b010);
        wait_cyc(1);
        rst_n = 1'b1;
        expect_out("R1 first cycle after reset", 1, 3'b111, 3'b010);
        wait_cyc(1);

        // Ladder select 1: level 16, window [8,56)
        auto_rts_en = 1'b1; trig_sel = 2'd1;
        rx_step("R2 below level 16",          15, 0, 0);
        rx_step("R2 at level 16",             16, 0, 1);
        rx_step("R6 below upper rung 56",     55, 0, 1);
        rx_step("R4 upper rung 56 reached",   56, 1, 1);
        rx_step("R6 inside window holds 1",   20, 1, 1);
        rx_step("R3 below level 16",          15, 1, 0);
        rx_step("R6 at lower rung 8 holds",    8, 1, 0);
        rx_step("R5 below lower rung 8",       7, 0, 0);

        // Select 3: upper rung saturates to 60
        trig_sel = 2'd3;
        rx_step("R4 sel3 at 59",              59, 0, 0);
        rx_step("R4 sel3 saturated rung 60",  60, 1, 1);
        rx_step("R6 sel3 at lower rung 56",   56, 1, 0);
        rx_step("R5 sel3 below 56",           55, 0, 0);

        // Select 0: lower rung saturates to 8
        trig_sel = 2'd0;
        rx_step("R2 sel0 at 15",              15, 0, 1);
        rx_step("R4 sel0 upper rung 16",      16, 1, 1);
        rx_step("R6 sel0 at saturated 8",      8, 1, 1);
        rx_step("R5 sel0 below 8",             7, 0, 0);

        // Select 2: level 56, upper rung 60
        trig_sel = 2'd2;
        rx_step("R2 sel2 at 56",              56, 0, 1);
        rx_step("R4 sel2 upper rung 60",      60, 1, 1);

        // Software RTS path
        auto_rts_en = 1'b0; sw_rts = 1'b0;
        expect_out("R7 software level 0", 1, 3'b100, 3'b000);
        wait_cyc(1);
        sw_rts = 1'b1;
        expect_out("R7 software level 1", 1, 3'b100, 3'b100);
        wait_cyc(1);
        sw_rts = 1'b0; fill_count = 7'd64;
        expect_out("R7 full FIFO ignored", 1, 3'b100, 3'b000);
        wait_cyc(1);
        trig_sel = 2'd1; fill_count = 7'd30; auto_rts_en = 1'b1;
        expect_out("R7 auto state cleared", 1, 3'b100, 3'b000);
        wait_cyc(2);

        // CTS with auto off
        auto_cts_en = 1'b0; cts_in = 1'b1;
        expect_out("R11 cts ignored when off", 3, 3'b010, 3'b010);
        expect_out("R11 cts ignored when off later", 5, 3'b010, 3'b010);
        wait_cyc(6);
        cts_in = 1'b0;
        wait_cyc(4);
        auto_cts_en = 1'b1;
        wait_cyc(2);
        cts_in = 1'b1;
        expect_out("R8 not yet after two edges", 2, 3'b010, 3'b010);
        expect_out("R9 stop on cts high", 3, 3'b010, 3'b000);
        wait_cyc(4);
        cts_in = 1'b0;
        expect_out("R8 still stopped after two edges", 2, 3'b010, 3'b000);
        expect_out("R9 resume on cts low", 3, 3'b010, 3'b010);
        wait_cyc(4);

        // Busy holds the permit
        tx_busy = 1'b1; cts_in = 1'b1;
        expect_out("R10 busy holds permit high", 5, 3'b010, 3'b010);
        wait_cyc(6);
        tx_busy = 1'b0;
        expect_out("R9 stop at character boundary", 1, 3'b010, 3'b000);
        wait_cyc(2);
        tx_busy = 1'b1; cts_in = 1'b0; auto_cts_en = 1'b0;
        expect_out("R10 busy holds permit low", 5, 3'b010, 3'b000);
        wait_cyc(6);
        tx_busy = 1'b0;
        expect_out("R11 permit after boundary", 1, 3'b010, 3'b010);
        wait_cyc(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule